// File: doc/BRIEF.md
# Selectable-Clock Modulus Counter

This block is a 16-bit up-counter whose restart value comes from a programmable modulus register. When the count passes 0xFFFF it does not fall back to zero. It takes the modulus value and sets a sticky overflow flag. A modulus of zero therefore gives a counter that runs through the whole 16-bit range. An edge on an external load pin can also copy the modulus into the counter. Software chooses whether rising edges, falling edges, both or neither do this.

The count advances on one of eight tick sources, chosen by software. Six are prescaler tick inputs. The other two are the rising or the falling edge of an external clock pin, which turns the block into an event counter. To get an interrupt after N events, software presets the counter to the two's complement of N. Both external pins pass through two-flop synchronisers before any edge is detected. A change of tick source blocks counting long enough that a stray edge cannot slip in. The current count can be placed on either or both of two time-base buses. A small register port reaches the modulus, the counter and a combined control/status word.

Top module: `modcnt_unit`

## Requirements
- R1: After reset the count, the modulus, every control field and the overflow flag are zero, `irq_req` is low, and both time-base buses are disabled with zero value.
- R2: Control bits [2:0] select the tick source. Codes 0 to 5 use `presc_tick[code]`, code 6 uses a rising edge of `ext_clk_pin` and code 7 uses a falling edge of it. Each system clock with the selected tick present adds one to the count, and a tick on any unselected source has no effect.
- R3: A tick taken while the count is 0xFFFF loads the modulus into the counter on that same clock and sets the overflow flag (control/status bit 10).
- R4: With a modulus of zero, the counter goes from 0xFFFF to 0x0000 and counts through the full range.
- R5: In the clock where a control write changes the tick-source field, and in the clock after it, the counter does not advance on a tick.
- R6: Each external pin passes through two synchronising flip-flops. A pin change becomes visible in the count on the third rising system clock edge after it. Read-only bit 11 shows the synchronised level of the load pin and read-only bit 12 shows that of the clock pin.
- R7: Control bit 3 enables loading on rising edges of `ext_load_pin` and bit 4 enables loading on falling edges; a load copies the modulus into the counter. A software counter write has priority over a pin load, and a pin load has priority over a tick.
- R8: A control write with bit 10 at zero clears the overflow flag, and one with bit 10 at one leaves it as it is. An overflow in the same clock as a clearing write leaves the flag set.
- R9: `irq_req` is high exactly while the overflow flag is set and the priority field (control bits [9:7], also on `irq_level`) is nonzero.
- R10: Control bit 5 drives bus A and bit 6 drives bus B. A driven bus has its enable high and carries the count. An undriven bus has its enable low and a value of zero.
- R11: Register address 0 is the modulus, 1 the counter and 2 the control/status word. A write takes effect on the next clock, reads are combinational, and address 3 reads as zero.
- R12: With the counter preset to the two's complement of N and an external edge selected, the Nth selected edge causes the overflow and sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_tick | input | 6 | Prescaler tick inputs, one per source code 0-5 |
| ext_clk_pin | input | 1 | Asynchronous external count clock |
| ext_load_pin | input | 1 | Asynchronous external modulus-load pin |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed interrupt priority |
| tbus_a_val | output | 16 | Time-base bus A value |
| tbus_a_en | output | 1 | Time-base bus A driven |
| tbus_b_val | output | 16 | Time-base bus B value |
| tbus_b_en | output | 1 | Time-base bus B driven |

## Verification
Each prescaler code is run with its own tick held low while all the others pulse, and then with its own tick pulsing. This shows that exactly one source is selected. The external clock pin is toggled under codes 6 and 7, and the counts show rising edges apart from falling ones. A single edge is timed to confirm the three-clock latency. Overflow is driven with a nonzero modulus, with a zero modulus and with a two's-complement preset, so that reload, free running and event counting can each be told apart. A tick source change is made while every prescaler ticks on every clock, which exposes any count taken during the two blocked clocks.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

    localparam int CNT_W     = 16;
    localparam int NUM_PRESC = 6;
    localparam int NUM_SRC   = NUM_PRESC + 2;
    localparam int LVL_W     = 3;

    typedef enum logic [2:0] {
        SRC_P0       = 3'd0,
        SRC_P1       = 3'd1,
        SRC_P2       = 3'd2,
        SRC_P3       = 3'd3,
        SRC_P4       = 3'd4,
        SRC_P5       = 3'd5,
        SRC_EXT_RISE = 3'd6,
        SRC_EXT_FALL = 3'd7
    } clk_src_e;

    // Writable control fields; first member sits at the top of the word.
    typedef struct packed {
        logic [LVL_W-1:0] irq_lvl;  // [9:7]
        logic             drv_b;    // [6]
        logic             drv_a;    // [5]
        logic             ld_fall;  // [4]
        logic             ld_rise;  // [3]
        clk_src_e         sel;      // [2:0]
    } ctrl_t;

    localparam int CTRL_W    = $bits(ctrl_t);
    localparam int BIT_OVF   = CTRL_W;
    localparam int BIT_LDPIN = CTRL_W + 1;
    localparam int BIT_CKPIN = CTRL_W + 2;

    typedef enum logic [1:0] {
        ADDR_MOD  = 2'd0,
        ADDR_CNT  = 2'd1,
        ADDR_CTRL = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;

    function automatic logic lvl_active(input logic [LVL_W-1:0] lvl);
        return lvl != '0;
    endfunction

endpackage

// File: rtl/modcnt_sync.sv
module modcnt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/modcnt_tick_sel.sv
module modcnt_tick_sel
    import modcnt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PRESC-1:0] presc_tick,
    input  logic                 ext_rise,
    input  logic                 ext_fall,
    input  clk_src_e             sel,
    input  logic                 sel_wr,
    output logic                 tick
);
    logic [NUM_SRC-1:0] src;
    logic               hold_q;

    assign src = {ext_fall, ext_rise, presc_tick};

    // Block the write clock (old source) and the following clock (new source).
    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= sel_wr;
    end

    assign tick = src[sel] & ~sel_wr & ~hold_q;
endmodule

// File: rtl/modcnt_core.sv
module modcnt_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         pin_load,
    input  logic         sw_wr,
    input  logic [W-1:0] sw_data,
    input  logic [W-1:0] modulus,
    output logic [W-1:0] count,
    output logic         ovf_pulse
);
    logic at_top;

    assign at_top    = (count == {W{1'b1}});
    assign ovf_pulse = tick & ~pin_load & ~sw_wr & at_top;

    always_ff @(posedge clk) begin
        if (rst)           count <= '0;
        else if (sw_wr)    count <= sw_data;
        else if (pin_load) count <= modulus;
        else if (tick)     count <= at_top ? modulus : count + W'(1);
    end
endmodule

// File: rtl/modcnt_unit.sv
module modcnt_unit
    import modcnt_pkg::*;
#(
    parameter int W           = CNT_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PRESC-1:0] presc_tick,
    input  logic                 ext_clk_pin,
    input  logic                 ext_load_pin,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [W-1:0]         reg_wdata,
    output logic [W-1:0]         reg_rdata,
    output logic                 irq_req,
    output logic [LVL_W-1:0]     irq_level,
    output logic [W-1:0]         tbus_a_val,
    output logic                 tbus_a_en,
    output logic [W-1:0]         tbus_b_val,
    output logic                 tbus_b_en
);
    ctrl_t          ctrl_q;
    logic [W-1:0]   modulus_q;
    logic [W-1:0]   count;
    logic           ovf_flag;
    logic           ovf_pulse;
    logic           tick;
    logic           sel_wr;
    logic           pin_load;
    logic           wr_mod, wr_cnt, wr_ctrl;
    logic           ck_lvl, ck_rise, ck_fall;
    logic           ld_lvl, ld_rise, ld_fall;

    assign wr_mod  = reg_we && (reg_addr_e'(reg_addr) == ADDR_MOD);
    assign wr_cnt  = reg_we && (reg_addr_e'(reg_addr) == ADDR_CNT);
    assign wr_ctrl = reg_we && (reg_addr_e'(reg_addr) == ADDR_CTRL);
    assign sel_wr  = wr_ctrl && (reg_wdata[2:0] != ctrl_q.sel);

    modcnt_sync #(.STAGES(SYNC_STAGES)) u_sync_ck (
        .clk(clk), .rst(rst), .din(ext_clk_pin),
        .level(ck_lvl), .rise(ck_rise), .fall(ck_fall)
    );

    modcnt_sync #(.STAGES(SYNC_STAGES)) u_sync_ld (
        .clk(clk), .rst(rst), .din(ext_load_pin),
        .level(ld_lvl), .rise(ld_rise), .fall(ld_fall)
    );

    modcnt_tick_sel u_tsel (
        .clk(clk), .rst(rst), .presc_tick(presc_tick),
        .ext_rise(ck_rise), .ext_fall(ck_fall),
        .sel(ctrl_q.sel), .sel_wr(sel_wr), .tick(tick)
    );

    assign pin_load = (ctrl_q.ld_rise & ld_rise) | (ctrl_q.ld_fall & ld_fall);

    modcnt_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .pin_load(pin_load),
        .sw_wr(wr_cnt), .sw_data(reg_wdata), .modulus(modulus_q),
        .count(count), .ovf_pulse(ovf_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            modulus_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q    <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (wr_mod)  modulus_q <= reg_wdata;
        end
    end

    // Sticky flag: overflow outranks a clearing write.
    always_ff @(posedge clk) begin
        if (rst)                              ovf_flag <= 1'b0;
        else if (ovf_pulse)                   ovf_flag <= 1'b1;
        else if (wr_ctrl && !reg_wdata[BIT_OVF]) ovf_flag <= 1'b0;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr_e'(reg_addr))
            ADDR_MOD:  reg_rdata = modulus_q;
            ADDR_CNT:  reg_rdata = count;
            ADDR_CTRL: begin
                reg_rdata[CTRL_W-1:0] = ctrl_q;
                reg_rdata[BIT_OVF]    = ovf_flag;
                reg_rdata[BIT_LDPIN]  = ld_lvl;
                reg_rdata[BIT_CKPIN]  = ck_lvl;
            end
            default:   reg_rdata = '0;
        endcase
    end

    assign irq_level  = ctrl_q.irq_lvl;
    assign irq_req    = ovf_flag && lvl_active(ctrl_q.irq_lvl);
    assign tbus_a_en  = ctrl_q.drv_a;
    assign tbus_b_en  = ctrl_q.drv_b;
    assign tbus_a_val = ctrl_q.drv_a ? count : '0;
    assign tbus_b_val = ctrl_q.drv_b ? count : '0;
endmodule

// File: rtl/modcnt_checker.sv
module modcnt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         pin_load,
    input logic         sw_wr,
    input logic         sel_wr,
    input logic [W-1:0] count,
    input logic [W-1:0] modulus,
    input logic         ovf_pulse,
    input logic         ovf_flag,
    input logic         irq_req,
    input logic         drv_a,
    input logic         drv_b,
    input logic [W-1:0] bus_a,
    input logic [W-1:0] bus_b
);
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !pin_load && !sw_wr && count != {W{1'b1}}) |=> count == $past(count) + W'(1));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !pin_load && !sw_wr && count == {W{1'b1}}) |=> count == $past(modulus));

    p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |=> ovf_flag);

    p_hold_now_r5: assert property (@(posedge clk) disable iff (rst)
        sel_wr |-> !tick);

    p_hold_next_r5: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> !tick);

    p_load_r7: assert property (@(posedge clk) disable iff (rst)
        (pin_load && !sw_wr) |=> count == $past(modulus));

    p_irq_r9: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ovf_flag);

    p_bus_a_r10: assert property (@(posedge clk) disable iff (rst)
        !drv_a |-> bus_a == '0);

    p_bus_b_r10: assert property (@(posedge clk) disable iff (rst)
        !drv_b |-> bus_b == '0);
endmodule

bind modcnt_unit modcnt_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .pin_load(pin_load),
    .sw_wr(wr_cnt), .sel_wr(sel_wr), .count(count), .modulus(modulus_q),
    .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag), .irq_req(irq_req),
    .drv_a(tbus_a_en), .drv_b(tbus_b_en), .bus_a(tbus_a_val), .bus_b(tbus_b_val)
);

// File: tb/sim_modcnt_unit.sv
`timescale 1ns/1ps
module sim_modcnt_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  presc = '0;
    logic        ck_pin = 1'b0;
    logic        ld_pin = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    logic [2:0]  lvl;
    logic [15:0] bus_a, bus_b;
    logic        en_a, en_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [1:0] A_MOD = 2'd0, A_CNT = 2'd1, A_CTL = 2'd2;

    always #2 clk = ~clk;

    modcnt_unit u0 (
        .clk(clk), .rst(rst), .presc_tick(presc), .ext_clk_pin(ck_pin),
        .ext_load_pin(ld_pin), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq_req(irq), .irq_level(lvl),
        .tbus_a_val(bus_a), .tbus_a_en(en_a), .tbus_b_val(bus_b), .tbus_b_en(en_b)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a; #0.1;
        d = rdata;
    endtask

    task automatic run(input logic [5:0] pat, input int n);
        presc = pat;
        repeat (n) @(posedge clk);
        #1 presc = '0;
    endtask

    task automatic ck_pulse();
        ck_pin = 1'b1; repeat (4) @(posedge clk); #1;
        ck_pin = 1'b0; repeat (4) @(posedge clk); #1;
    endtask

    task automatic ld_level(input logic v);
        ld_pin = v; repeat (4) @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(A_CNT, d);  check("R1 count", d, 0);
        rd(A_MOD, d);  check("R1 modulus", d, 0);
        rd(A_CTL, d);  check("R1 control", d, 0);
        check("R1 irq", irq, 0);
        check("R1 buses", {en_a, en_b, bus_a, bus_b}, 0);
    endtask

    task automatic t_prescaler_sel();
        logic [15:0] d;
        for (int i = 0; i < 6; i++) begin
            wr(A_CTL, 16'(i));
            wr(A_CNT, 16'h0);
            run(~(6'b1 << i), 3);
            run(6'b1 << i, 3);
            rd(A_CNT, d);
            check($sformatf("R2 prescaler code %0d", i), d, 3);
        end
    endtask

    task automatic t_switch_hold();
        logic [15:0] d;
        wr(A_CTL, 16'h0);
        presc = 6'h3F;
        wr(A_CNT, 16'd100);
        wr(A_CTL, 16'h3);
        repeat (3) @(posedge clk); #1;
        presc = '0;
        rd(A_CNT, d);
        check("R5 no count across source change", d, 102);
    endtask

    task automatic t_overflow();
        logic [15:0] d;
        wr(A_CTL, 16'h0);
        wr(A_MOD, 16'h1234);
        wr(A_CNT, 16'hFFFE);
        run(6'b1, 1);
        rd(A_CNT, d); check("R3 reach top", d, 16'hFFFF);
        rd(A_CTL, d); check("R3 flag not yet", d[10], 0);
        run(6'b1, 1);
        rd(A_CNT, d); check("R3 reload modulus", d, 16'h1234);
        rd(A_CTL, d); check("R3 flag set", d[10], 1);
        check("R9 irq off at level 0", irq, 0);
        wr(A_CTL, 16'h0400 | (16'd5 << 7));
        check("R9 irq on", irq, 1);
        check("R9 level out", lvl, 5);
        wr(A_CTL, 16'd5 << 7);
        rd(A_CTL, d); check("R8 cleared", d[10], 0);
        check("R9 irq off after clear", irq, 0);
        wr(A_CNT, 16'hFFFF);
        @(negedge clk);
        presc = 6'b1; addr = A_CTL; wdata = 16'd5 << 7; we = 1'b1;
        @(posedge clk); #1;
        we = 1'b0; presc = '0;
        rd(A_CTL, d); check("R8 overflow beats clear", d[10], 1);
        wr(A_MOD, 16'h0);
        wr(A_CNT, 16'hFFFF);
        run(6'b1, 1);
        rd(A_CNT, d); check("R4 free-run wraps to 0", d, 0);
    endtask

    task automatic t_ext_clock();
        logic [15:0] d;
        wr(A_CTL, 16'h6);
        wr(A_MOD, 16'h0);
        wr(A_CNT, 16'hFFFD);
        repeat (2) @(posedge clk); #1;
        ck_pulse(); ck_pulse();
        rd(A_CNT, d); check("R12 two events", d, 16'hFFFF);
        rd(A_CTL, d); check("R12 no flag before Nth", d[10], 0);
        ck_pulse();
        rd(A_CTL, d); check("R12 flag on third event", d[10], 1);
        wr(A_CTL, 16'h7);
        wr(A_CNT, 16'h0);
        ck_pin = 1'b1; repeat (4) @(posedge clk); #1;
        rd(A_CNT, d); check("R2 rising ignored under falling code", d, 0);
        rd(A_CTL, d); check("R6 clock pin status", d[12], 1);
        ck_pin = 1'b0; repeat (4) @(posedge clk); #1;
        rd(A_CNT, d); check("R2 falling counted", d, 1);
        wr(A_CTL, 16'h6);
        wr(A_CNT, 16'h0);
        repeat (2) @(posedge clk); #1;
        ck_pin = 1'b1;
        repeat (2) @(posedge clk); #1;
        rd(A_CNT, d); check("R6 not before third edge", d, 0);
        @(posedge clk); #1;
        rd(A_CNT, d); check("R6 at third edge", d, 1);
        ck_pin = 1'b0; repeat (4) @(posedge clk); #1;
    endtask

    task automatic t_load_pin();
        logic [15:0] d;
        wr(A_CTL, 16'h0);
        wr(A_MOD, 16'h0ABC);
        wr(A_CNT, 16'h5);
        ld_level(1'b1); ld_level(1'b0);
        rd(A_CNT, d); check("R7 disabled pin ignored", d, 5);
        wr(A_CTL, 16'h0008);
        ld_level(1'b1);
        rd(A_CNT, d); check("R7 rising load", d, 16'h0ABC);
        rd(A_CTL, d); check("R6 load pin status", d[11], 1);
        wr(A_CNT, 16'h5);
        ld_level(1'b0);
        rd(A_CNT, d); check("R7 falling ignored", d, 5);
        wr(A_CTL, 16'h0010);
        ld_level(1'b1);
        rd(A_CNT, d); check("R7 rising ignored", d, 5);
        ld_level(1'b0);
        rd(A_CNT, d); check("R7 falling load", d, 16'h0ABC);
    endtask

    task automatic t_buses_regs();
        logic [15:0] d;
        wr(A_CTL, 16'h0);
        wr(A_CNT, 16'h0077);
        wr(A_CTL, 16'h0020);
        #0.1;
        check("R10 A only", {en_a, bus_a, en_b, bus_b}, {1'b1, 16'h0077, 1'b0, 16'h0});
        wr(A_CTL, 16'h0060);
        #0.1;
        check("R10 both", {en_a, bus_a, en_b, bus_b}, {1'b1, 16'h0077, 1'b1, 16'h0077});
        rd(2'd3, d); check("R11 unused address", d, 0);
        wr(A_MOD, 16'hBEEF);
        rd(A_MOD, d); check("R11 modulus readback", d, 16'hBEEF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_prescaler_sel();
        t_switch_hold();
        t_overflow();
        t_ext_clock();
        t_load_pin();
        t_buses_regs();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule